// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer, 36 bits wide by default, whose write side and read side run on independent clocks. Words can be written and read in the same cycle. The write and read pointers pass between the clock domains as gray codes through two-flop synchronizers. From those pointers the block derives empty, full, half-full, almost-empty and almost-full indications. The two almost thresholds sit in offset registers. After a master reset they take a preset value chosen by a select input. Software can reload them afterwards, either with one parallel load from the data bus or with a bit-serial shift.

Three settings are captured while the master reset is held: the offset preset, the output timing mode and the almost-flag timing mode. In the standard output mode a read enable fetches each word. In first-word-fall-through mode the head word appears on the output by itself, and the status pins change meaning to "output ready" and "input ready". A partial reset empties the buffer but keeps the offsets and the modes. A retransmit pulse moves reading back to the first stored word in the same read clock cycle.

Top module: `fifo_dc_progflag`

## Requirements
- R1: While `mrst_n` is low, each `wclk` edge captures `ofs_sel`, `fwft_sel` and `flag_async_sel`. Once reset is released in standard mode (`fwft_sel`=0), the flags read `rd_flag`=1 (empty), `wr_flag`=0 (not full), `half_full`=0, `almost_empty`=1 and `almost_full`=0. In fall-through mode (`fwft_sel`=1), `rd_flag`=0 (no output ready) and `wr_flag`=1 (input ready).
- R2: Words come out in the order they were written, including when writes and reads run at the same time on unrelated clocks.
- R3: With DEPTH words stored in RAM, the full indication is active: `wr_flag`=1 in standard mode. A write attempted while full stores nothing and does not move the write pointer.
- R4: In standard mode, a read attempted while empty changes neither the read pointer nor the flags.
- R5: `half_full` is 1 exactly when the stored count exceeds DEPTH/2.
- R6: `almost_empty` is 1 when the stored count is at most the empty offset. `almost_full` is 1 when the free space (DEPTH minus the count) is at most the full offset.
- R7: After a master reset, both offsets equal min(2^(3+`ofs_sel`) − 1, DEPTH − 1). For example, `ofs_sel`=0 gives 7 and `ofs_sel`=3 gives 63.
- R8: A `wclk` edge with `ld`=1 loads the empty offset from `din[AW-1:0]` and the full offset from `din[18 +: AW]`, where AW = log2(DEPTH). No FIFO write takes place on that edge.
- R9: Each `wclk` edge with `sen`=1 and `ld`=0 shifts `sdi` into bit 0 of the empty offset. The top bit of the empty offset moves into bit 0 of the full offset. After 2·AW edges, the first bit sent sits at the top bit of the full offset.
- R10: A low pulse on `prst_n` empties the FIFO and restores the reset flag state. The offsets and both mode settings keep their values.
- R11: With `flag_async_sel`=1, the almost flags follow the count in the same clock edge that moves the pointer. With `flag_async_sel`=0, they follow one edge later, each in its own domain (`almost_empty` on `rclk`, `almost_full` on `wclk`).
- R12: In fall-through mode the head word sits on `dout` with `rd_flag`=1 and no read enable needed, and `ren` consumes it. In standard mode, `dout` changes only on a `rclk` edge that has `ren`=1 while not empty.
- R13: A `rclk` edge with `rt`=1 sets reading back to location 0. In standard mode, the next read returns the first word written since reset. In fall-through mode, that word is on `dout` right after the `rt` edge. The count of words written since the last reset must not exceed DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, active low |
| ofs_sel | input | 3 | Offset preset select, captured in master reset |
| fwft_sel | input | 1 | 1 selects fall-through output mode, captured in master reset |
| flag_async_sel | input | 1 | 1 selects same-edge almost-flag timing, captured in master reset |
| wen | input | 1 | Write enable |
| ld | input | 1 | Parallel offset load strobe |
| sen | input | 1 | Serial offset shift enable |
| sdi | input | 1 | Serial offset data |
| din | input | DW | Write data |
| ren | input | 1 | Read enable |
| rt | input | 1 | Retransmit |
| dout | output | DW | Read data |
| rd_flag | output | 1 | Empty (standard) or output ready (fall-through) |
| wr_flag | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | More than DEPTH/2 words stored |
| almost_empty | output | 1 | Count at or below the empty offset |
| almost_full | output | 1 | Free space at or below the full offset |

## Verification
The bench probes each flag on both sides of its threshold, one word apart: DEPTH/2 against DEPTH/2+1, and the offset against the offset plus one. An off-by-one compare would show up there as a flag that moves a word early or late. It fills past DEPTH and then drains, so an extra write accepted while full would appear as a lost or repeated word. It also reads an empty FIFO before writing, which catches a pointer that drifts. A partial reset follows a parallel load to show that the offsets survive. The almost-empty flag is sampled one and two read edges after a crossing, which separates the two timing modes. Retransmit is tried in both output modes, so a design that lags one word behind would present the wrong data.

// File: rtl/fifo_dc_progflag.sv
module fifo_dc_progflag #(
  parameter int DW    = 36,
  parameter int DEPTH = 1024
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic [2:0]    ofs_sel,
  input  logic          fwft_sel,
  input  logic          flag_async_sel,
  input  logic          wen,
  input  logic          ld,
  input  logic          sen,
  input  logic          sdi,
  input  logic [DW-1:0] din,
  input  logic          ren,
  input  logic          rt,
  output logic [DW-1:0] dout,
  output logic          rd_flag,
  output logic          wr_flag,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int FULL_LSB = 18;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic rst_n;
  assign rst_n = mrst_n & prst_n;

  logic [DW-1:0] mem [DEPTH];

  // settings: captured during master reset, kept through partial reset
  logic [AW-1:0] ae_off, af_off;
  logic          fwft_m, async_m;
  logic [31:0]   preset_w;
  logic [AW-1:0] preset;
  assign preset_w = (32'd8 << ofs_sel) - 32'd1;
  assign preset   = (preset_w > 32'(DEPTH - 1)) ? AW'(DEPTH - 1) : preset_w[AW-1:0];

  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      ae_off  <= preset;
      af_off  <= preset;
      fwft_m  <= fwft_sel;
      async_m <= flag_async_sel;
    end else if (ld) begin
      ae_off <= din[AW-1:0];
      af_off <= din[FULL_LSB +: AW];
    end else if (sen) begin
      {af_off, ae_off} <= {af_off[AW-2:0], ae_off, sdi};
    end
  end

  // write domain
  logic [PW-1:0] wptr, wgray, rq1, rq2, rbin_w, wcount, wfree;
  logic          full, do_wr, af_c, af_q;
  assign rbin_w = g2b(rq2);
  assign wcount = wptr - rbin_w;
  assign wfree  = PW'(DEPTH) - wcount;
  assign full   = (wcount == PW'(DEPTH));
  assign do_wr  = wen && !ld && !full;
  assign af_c   = (wfree <= {1'b0, af_off});

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0; af_q <= 1'b0;
    end else begin
      rq1  <= rgray;
      rq2  <= rq1;
      af_q <= af_c;
      if (do_wr) begin
        wptr  <= wptr + 1'b1;
        wgray <= (wptr + 1'b1) ^ ((wptr + 1'b1) >> 1);
      end
    end
  end

  always_ff @(posedge wclk) if (do_wr) mem[wptr[AW-1:0]] <= din;

  assign wr_flag     = fwft_m ? !full : full;
  assign half_full   = wcount > PW'(DEPTH / 2);
  assign almost_full = async_m ? af_c : af_q;

  // read domain
  logic [PW-1:0] rptr, rptr_nx, rgray, wq1, wq2, wbin_r, ram_cnt, rcount;
  logic          empty, fetch, ovld, ae_c, ae_q;
  assign wbin_r  = g2b(wq2);
  assign ram_cnt = wbin_r - rptr;
  assign empty   = (ram_cnt == '0);
  assign fetch   = fwft_m ? (!empty && (!ovld || ren)) : (ren && !empty);
  assign rcount  = ram_cnt + {{(PW-1){1'b0}}, fwft_m & ovld};
  assign ae_c    = (rcount <= {1'b0, ae_off});

  always_comb begin
    rptr_nx = rptr;
    if (rt)         rptr_nx = (fwft_m && wbin_r != '0) ? PW'(1) : '0;
    else if (fetch) rptr_nx = rptr + 1'b1;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0; ovld <= 1'b0; ae_q <= 1'b1;
    end else begin
      wq1   <= wgray;
      wq2   <= wq1;
      ae_q  <= ae_c;
      rptr  <= rptr_nx;
      rgray <= rptr_nx ^ (rptr_nx >> 1);
      if (rt)         ovld <= fwft_m && (wbin_r != '0);
      else if (fetch) ovld <= 1'b1;
      else if (ren)   ovld <= 1'b0;
    end
  end

  always_ff @(posedge rclk) begin
    if (rt && fwft_m) dout <= mem[0];
    else if (fetch)   dout <= mem[rptr[AW-1:0]];
  end

  assign rd_flag      = fwft_m ? ovld : empty;
  assign almost_empty = async_m ? ae_c : ae_q;

  // checks
  assert_wr_hold_full_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    full && wen |=> wptr == $past(wptr));
  assert_count_bound_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    wcount <= PW'(DEPTH));
  assert_wgray_step_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  assert_rd_hold_empty_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    !fwft_m && empty && ren && !rt |=> rptr == $past(rptr));
  assert_fwft_hold_R12: assert property (@(posedge rclk) disable iff (!rst_n)
    fwft_m && ovld && !ren && !rt |=> ovld && $stable(dout));
  assert_rt_ready_R13: assert property (@(posedge rclk) disable iff (!rst_n)
    rt && fwft_m && (wbin_r != '0) |=> ovld && (rptr == PW'(1)));
endmodule

// File: tb/test_fifo_dc_progflag.sv
`timescale 1ns/1ps
module test_fifo_dc_progflag;
  localparam int DW = 36;
  localparam int DEPTH = 1024;

  logic wclk = 0, rclk = 0;
  logic mrst_n = 1, prst_n = 1;
  logic [2:0] ofs_sel = 0;
  logic fwft_sel = 0, flag_async_sel = 0;
  logic wen = 0, ld = 0, sen = 0, sdi = 0, ren = 0, rt = 0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic rd_flag, wr_flag, half_full, almost_empty, almost_full;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  fifo_dc_progflag #(.DW(DW), .DEPTH(DEPTH)) i_fifo_dc_progflag (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .ofs_sel(ofs_sel), .fwft_sel(fwft_sel), .flag_async_sel(flag_async_sel),
    .wen(wen), .ld(ld), .sen(sen), .sdi(sdi), .din(din),
    .ren(ren), .rt(rt), .dout(dout), .rd_flag(rd_flag), .wr_flag(wr_flag),
    .half_full(half_full), .almost_empty(almost_empty), .almost_full(almost_full));

  int checks = 0, errors = 0;
  int seq = 0;
  logic cur_fwft = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] hist[$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
  endtask

  task automatic mreset(input logic [2:0] s, input logic f, input logic a);
    @(negedge wclk);
    mrst_n = 0; ofs_sel = s; fwft_sel = f; flag_async_sel = a;
    repeat (4) @(negedge wclk);
    mrst_n = 1; cur_fwft = f;
    q.delete(); hist.delete();
    settle();
  endtask

  task automatic preset_pulse();
    @(negedge wclk); prst_n = 0;
    repeat (4) @(negedge wclk); prst_n = 1;
    q.delete(); hist.delete();
    settle();
  endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      din = {4'h9, 32'(seq)}; seq++; wen = 1;
      if (!(cur_fwft ? !wr_flag : wr_flag)) begin q.push_back(din); hist.push_back(din); end
    end
    @(negedge wclk); wen = 0;
  endtask

  task automatic read_n(input int n, input string req);
    logic pend = 0;
    logic [DW-1:0] exp = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      if (pend) begin chk(req, dout, exp); pend = 0; end
      if (cur_fwft) begin
        if (rd_flag) begin
          if (q.size() == 0) chk(req, 1, 0);
          else begin chk(req, dout, q[0]); void'(q.pop_front()); end
        end
      end else if (!rd_flag) begin
        if (q.size() == 0) chk(req, 1, 0);
        else begin exp = q.pop_front(); pend = 1; end
      end
      ren = 1;
    end
    @(negedge rclk);
    if (pend) chk(req, dout, exp);
    ren = 0;
  endtask

  initial begin
    #500us;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state, standard mode, preset 7
    mreset(3'd0, 1'b0, 1'b1);
    chk("R1 empty", rd_flag, 1); chk("R1 full", wr_flag, 0); chk("R1 hf", half_full, 0);
    chk("R1 ae", almost_empty, 1); chk("R1 af", almost_full, 0);

    // R4 read while empty ignored
    read_n(3, "R4");
    chk("R4 still empty", rd_flag, 1);
    write_n(1); settle();
    read_n(1, "R4 no drift");
    settle(); chk("R4 empty after", rd_flag, 1);

    // R3 R5 R6 R7 fill sweep with preset offsets 7/7
    write_n(7); settle(); chk("R6 R7 ae at 7", almost_empty, 1);
    write_n(1); settle(); chk("R6 R7 ae at 8", almost_empty, 0);
    write_n(504); settle(); chk("R5 hf at 512", half_full, 0);
    write_n(1); settle(); chk("R5 hf at 513", half_full, 1);
    write_n(503); settle(); chk("R6 af at 1016", almost_full, 0);
    write_n(1); settle(); chk("R6 af at 1017", almost_full, 1);
    write_n(6); settle(); chk("R3 not full 1023", wr_flag, 0);
    write_n(1); settle(); chk("R3 full 1024", wr_flag, 1);
    write_n(2); settle(); chk("R3 model count", q.size(), DEPTH);
    read_n(DEPTH, "R3 drain");
    settle(); chk("R3 empty after drain", rd_flag, 1); chk("R3 model empty", q.size(), 0);

    // R7 preset select 3 -> 63
    mreset(3'd3, 1'b0, 1'b1);
    write_n(63); settle(); chk("R7 ae at 63", almost_empty, 1);
    write_n(1); settle(); chk("R7 ae at 64", almost_empty, 0);

    // R8 parallel load: empty offset 3, full offset 5
    mreset(3'd0, 1'b0, 1'b1);
    @(negedge wclk); ld = 1; din = '0; din[9:0] = 10'd3; din[27:18] = 10'd5;
    @(negedge wclk); ld = 0;
    settle(); chk("R8 ld no write", rd_flag, 1);
    write_n(3); settle(); chk("R8 ae at 3", almost_empty, 1);
    write_n(1); settle(); chk("R8 ae at 4", almost_empty, 0);
    write_n(1014); settle(); chk("R8 af at 1018", almost_full, 0);
    write_n(1); settle(); chk("R8 af at 1019", almost_full, 1);

    // R10 partial reset keeps offsets
    preset_pulse();
    chk("R10 empty", rd_flag, 1); chk("R10 af clear", almost_full, 0); chk("R10 hf clear", half_full, 0);
    write_n(3); settle(); chk("R10 ae kept at 3", almost_empty, 1);
    write_n(1); settle(); chk("R10 ae kept at 4", almost_empty, 0);
    read_n(4, "R10 data");

    // R9 serial load: full offset 20, empty offset 10
    mreset(3'd0, 1'b0, 1'b1);
    begin
      logic [19:0] bits = {10'd20, 10'd10};
      for (int i = 19; i >= 0; i--) begin
        @(negedge wclk); sen = 1; sdi = bits[i];
      end
      @(negedge wclk); sen = 0;
    end
    settle();
    write_n(10); settle(); chk("R9 ae at 10", almost_empty, 1);
    write_n(1); settle(); chk("R9 ae at 11", almost_empty, 0);
    write_n(993); settle(); chk("R9 af at 1004", almost_full, 1);

    // R11 same-edge almost flag
    mreset(3'd0, 1'b0, 1'b1);
    write_n(8); settle(); chk("R11 async ae before", almost_empty, 0);
    @(negedge rclk); ren = 1;
    @(negedge rclk); ren = 0;
    chk("R11 async ae same edge", almost_empty, 1);
    // R11 registered almost flag
    mreset(3'd0, 1'b0, 1'b0);
    write_n(8); settle(); chk("R11 sync ae before", almost_empty, 0);
    @(negedge rclk); ren = 1;
    @(negedge rclk); ren = 0;
    chk("R11 sync ae one edge", almost_empty, 0);
    @(negedge rclk); chk("R11 sync ae two edges", almost_empty, 1);

    // R13 retransmit in standard mode
    mreset(3'd0, 1'b0, 1'b1);
    write_n(5); settle();
    read_n(3, "R12 std");
    @(negedge rclk); rt = 1;
    @(negedge rclk); rt = 0;
    q = hist;
    read_n(5, "R13 std replay");
    settle(); chk("R13 std empty", rd_flag, 1);

    // R12 R13 fall-through mode
    mreset(3'd0, 1'b1, 1'b1);
    chk("R1 fwft or", rd_flag, 0); chk("R1 fwft ir", wr_flag, 1);
    write_n(4); settle();
    chk("R12 fwft ready", rd_flag, 1); chk("R12 fwft head", dout, hist[0]);
    read_n(2, "R12 fwft");
    @(negedge rclk); rt = 1;
    @(negedge rclk); rt = 0;
    chk("R13 fwft ready", rd_flag, 1); chk("R13 fwft head", dout, hist[0]);
    q = hist;
    read_n(4, "R13 fwft replay");
    settle(); chk("R12 fwft drained", rd_flag, 0);

    // R2 concurrent traffic
    mreset(3'd0, 1'b0, 1'b1);
    fork
      write_n(200);
      read_n(320, "R2 concurrent");
    join
    settle();
    read_n(20, "R2 tail");
    settle(); chk("R2 model drained", q.size(), 0); chk("R2 empty", rd_flag, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule